// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the program memory address for a small 4-bit controller core. The address is the concatenation of a chapter field, a page field and an in-page location counter. With the default widths this is 2, 4 and 6 bits, so the address is 12 bits wide. The page and chapter fields are never written straight from an opcode. Software first stages a target page in a page buffer and, if it needs to, moves the low page-buffer bits into a chapter buffer. A later taken branch, call or return then copies the buffers into the live fields.

There is one level of subroutine. A call latch records that a subroutine is active. While the latch is set, a taken branch or call leaves the live page alone and does not overwrite the saved return location. One return then resumes at the location that follows the original call. The decoder supplies the decoded operation bits, the immediate field, the status bit and a step strobe. Every state change happens only on a clock edge where the step strobe is high.

Top module: `paged_addr_seq`

## Requirements
- R1: `rom_addr` is {chapter, page, counter}, with the chapter in the top bits and the counter in the low 6 bits. Reset clears the counter, page, chapter, both buffers, the return location, the chapter save and the call latch.
- R2: While `step` is low, no register changes, whatever the operation inputs are.
- R3: On a step where the counter is not loaded, the counter advances by one and wraps from 63 to 0. Page and chapter stay the same.
- R4: A branch or call with `status` = 0 is not taken. Page, chapter, buffers and latch keep their values, and the counter advances.
- R5: A taken branch loads the chapter from the chapter buffer and the counter from `imm`. It loads the page from the page buffer only when the call latch is clear.
- R6: A taken call with the latch clear saves counter+1 (wrapping) as the return location and saves the current chapter. It sets the latch and loads the page from the page buffer.
- R7: Every taken call loads the chapter from the chapter buffer, the page buffer with the page as it was before the call, and the counter from `imm`. With the latch already set, the return location, chapter save and page are left unchanged.
- R8: Every return loads the page from the page buffer. With the latch set, a return restores the counter and chapter from the saved values and clears the latch. With the latch clear, the counter advances and the chapter is unchanged.
- R9: Load-page writes `imm[3:0]` into the page buffer without changing the live page. If it falls on the same step as a call, the load-page value is the one the page buffer keeps.
- R10: Transfer-page-to-chapter writes the low 2 bits of the page buffer into the chapter buffer. On the same step as load-page, it uses the page buffer value from before that step.
- R11: When several control-flow inputs are high on one step, return takes priority over call, and call takes priority over branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction step strobe |
| op_br | input | 1 | Decoded conditional branch |
| op_call | input | 1 | Decoded conditional call |
| op_ret | input | 1 | Decoded return |
| op_ldp | input | 1 | Decoded load page buffer |
| op_tpc | input | 1 | Decoded transfer page buffer to chapter buffer |
| status | input | 1 | Condition bit for branch and call |
| imm | input | 6 | Opcode immediate field |
| rom_addr | output | 12 | Program memory address |

## Verification
Several operations can land on the same step. Load-page can coincide with a taken call, which also writes the page buffer. Transfer can coincide with load-page, which changes the page buffer it reads. Return, call and branch can be raised together. The vector table sets these combinations on single steps with the call latch both set and clear. Each outcome is then judged from the address produced by that step or by a later return, which exposes which value each buffer took.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;

   typedef struct packed {
      logic br;
      logic call;
      logic ret;
      logic ldp;
      logic tpc;
   } pas_op_t;

   typedef struct packed {
      logic go_br;
      logic go_call;
      logic go_ret;
      logic ldp;
      logic tpc;
      logic load_ctr;
   } pas_act_t;

   // Priority: return over call over branch; branch and call need status.
   function automatic pas_act_t pas_resolve(input pas_op_t op, input logic step,
                                            input logic status, input logic latch);
      pas_act_t a;
      a.go_ret   = step & op.ret;
      a.go_call  = step & op.call & status & ~op.ret;
      a.go_br    = step & op.br & status & ~op.ret & ~op.call;
      a.ldp      = step & op.ldp;
      a.tpc      = step & op.tpc;
      a.load_ctr = a.go_br | a.go_call | (a.go_ret & latch);
      return a;
   endfunction

endpackage

// File: rtl/pas_inpage_ctr.sv
module pas_inpage_ctr #(
   parameter int PC_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            load,
   input  logic [PC_W-1:0] load_val,
   output logic [PC_W-1:0] ctr,
   output logic [PC_W-1:0] ctr_seq
);
   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   // natural wrap of the binary sum keeps the counter inside the page
   assign ctr_seq = ctr + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctr <= '0;
      else if (step)
         ctr <= load ? load_val : ctr_seq;
   end
endmodule

// File: rtl/pas_bank_regs.sv
module pas_bank_regs
   import paged_addr_pkg::*;
#(
   parameter int CH_W = 2,
   parameter int PG_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pas_act_t        act,
   input  logic            latch,
   input  logic [PG_W-1:0] ldp_val,
   input  logic [CH_W-1:0] ch_restore,
   output logic [PG_W-1:0] page,
   output logic [CH_W-1:0] chap,
   output logic [PG_W-1:0] pbuf,
   output logic [CH_W-1:0] cbuf
);
   logic [CH_W-1:0] pbuf_low;
   logic            page_take;

   generate
      if (CH_W == PG_W) begin : g_full
         assign pbuf_low = pbuf;
      end else begin : g_slice
         assign pbuf_low = pbuf[CH_W-1:0];
      end
   endgenerate

   assign page_take = act.go_ret | ((act.go_br | act.go_call) & ~latch);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page <= '0;
         chap <= '0;
         pbuf <= '0;
         cbuf <= '0;
      end else begin
         if (page_take)
            page <= pbuf;
         if (act.ldp)
            pbuf <= ldp_val;
         else if (act.go_call)
            pbuf <= page;
         if (act.go_br | act.go_call)
            chap <= cbuf;
         else if (act.go_ret & latch)
            chap <= ch_restore;
         if (act.tpc)
            cbuf <= pbuf_low;
      end
   end
endmodule

// File: rtl/pas_return_unit.sv
module pas_return_unit
   import paged_addr_pkg::*;
#(
   parameter int PC_W = 6,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pas_act_t        act,
   input  logic [PC_W-1:0] ctr_seq,
   input  logic [CH_W-1:0] chap,
   output logic            latch,
   output logic [PC_W-1:0] ret_loc,
   output logic [CH_W-1:0] ch_save
);
   logic first_call;

   assign first_call = act.go_call & ~latch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch   <= 1'b0;
         ret_loc <= '0;
         ch_save <= '0;
      end else begin
         if (first_call) begin
            ret_loc <= ctr_seq;
            ch_save <= chap;
         end
         if (act.go_call)
            latch <= 1'b1;
         else if (act.go_ret)
            latch <= 1'b0;
      end
   end
endmodule

// File: rtl/paged_addr_seq.sv
module paged_addr_seq
   import paged_addr_pkg::*;
#(
   parameter int CH_W = 2,
   parameter int PG_W = 4,
   parameter int PC_W = 6,
   localparam int ADDR_W = CH_W + PG_W + PC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              op_br,
   input  logic              op_call,
   input  logic              op_ret,
   input  logic              op_ldp,
   input  logic              op_tpc,
   input  logic              status,
   input  logic [PC_W-1:0]   imm,
   output logic [ADDR_W-1:0] rom_addr
);
   generate
      if (CH_W < 1 || CH_W > PG_W) begin : g_bad_ch
         $error("chapter width must be between 1 and the page width");
      end
      if (PG_W > PC_W) begin : g_bad_pg
         $error("page buffer is loaded from the immediate, so PG_W <= PC_W");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("in-page counter needs at least 2 bits");
      end
   endgenerate

   pas_op_t         op;
   pas_act_t        act;
   logic            call_latch;
   logic [PC_W-1:0] ctr, ctr_seq, ret_loc, ctr_load;
   logic [PG_W-1:0] page, pbuf;
   logic [CH_W-1:0] chap, cbuf, ch_save;

   assign op       = '{br: op_br, call: op_call, ret: op_ret, ldp: op_ldp, tpc: op_tpc};
   assign act      = pas_resolve(op, step, status, call_latch);
   assign ctr_load = act.go_ret ? ret_loc : imm;

   pas_inpage_ctr #(.PC_W(PC_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .load     (act.load_ctr),
      .load_val (ctr_load),
      .ctr      (ctr),
      .ctr_seq  (ctr_seq)
   );

   pas_bank_regs #(.CH_W(CH_W), .PG_W(PG_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (act),
      .latch      (call_latch),
      .ldp_val    (imm[PG_W-1:0]),
      .ch_restore (ch_save),
      .page       (page),
      .chap       (chap),
      .pbuf       (pbuf),
      .cbuf       (cbuf)
   );

   pas_return_unit #(.PC_W(PC_W), .CH_W(CH_W)) u_ret (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .ctr_seq (ctr_seq),
      .chap    (chap),
      .latch   (call_latch),
      .ret_loc (ret_loc),
      .ch_save (ch_save)
   );

   assign rom_addr = {chap, page, ctr};
endmodule

// File: rtl/paged_addr_seq_chk.sv
module paged_addr_seq_chk #(
   parameter int CH_W = 2,
   parameter int PG_W = 4,
   parameter int PC_W = 6,
   localparam int ADDR_W = CH_W + PG_W + PC_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic              op_br,
   input logic              op_call,
   input logic              op_ret,
   input logic              op_tpc,
   input logic              status,
   input logic [ADDR_W-1:0] rom_addr,
   input logic              latch,
   input logic [PC_W-1:0]   ret_loc,
   input logic [PG_W-1:0]   pbuf,
   input logic [CH_W-1:0]   cbuf
);
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(rom_addr) && $stable(latch));

   a_r4_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      step && (op_br || op_call) && !op_ret && !status
      |=> $stable(rom_addr[ADDR_W-1:PC_W]) && $stable(latch));

   a_r5_br_in_sub_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_br && status && !op_call && !op_ret && latch
      |=> $stable(rom_addr[PC_W+PG_W-1:PC_W]) && latch);

   a_r6_call_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_call && status && !op_ret |=> latch);

   a_r7_nested_call_keeps_return: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_call && status && !op_ret && latch |=> $stable(ret_loc));

   a_r8_ret_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_ret |=> !latch);

   a_r10_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      step && op_tpc |=> cbuf == $past(pbuf[CH_W-1:0]));
endmodule

bind paged_addr_seq paged_addr_seq_chk #(.CH_W(CH_W), .PG_W(PG_W), .PC_W(PC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step     (step),
   .op_br    (op_br),
   .op_call  (op_call),
   .op_ret   (op_ret),
   .op_tpc   (op_tpc),
   .status   (status),
   .rom_addr (rom_addr),
   .latch    (call_latch),
   .ret_loc  (ret_loc),
   .pbuf     (pbuf),
   .cbuf     (cbuf)
);

// File: tb/paged_addr_seq_test.sv
module paged_addr_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic        op_br = 1'b0, op_call = 1'b0, op_ret = 1'b0, op_ldp = 1'b0, op_tpc = 1'b0;
   logic        status = 1'b0;
   logic [5:0]  imm = '0;
   logic [11:0] rom_addr;
   int          nvec = 0;
   int          nfail = 0;

   always #5 clk = ~clk;

   paged_addr_seq uut (
      .clk (clk), .rst_n (rst_n), .step (step),
      .op_br (op_br), .op_call (op_call), .op_ret (op_ret),
      .op_ldp (op_ldp), .op_tpc (op_tpc), .status (status),
      .imm (imm), .rom_addr (rom_addr)
   );

   // {br,call,ret,ldp,tpc}, status, imm, expected address after the step
   localparam logic [23:0] VEC [0:19] = '{
      {5'b00000, 1'b0, 6'h00, 12'h001},  // R3 advance
      {5'b00010, 1'b0, 6'h05, 12'h002},  // R9 page buffer 5, live page held
      {5'b00001, 1'b0, 6'h00, 12'h003},  // R10 chapter buffer 1
      {5'b10000, 1'b0, 6'h20, 12'h004},  // R4 branch not taken
      {5'b10000, 1'b1, 6'h10, 12'h550},  // R5 branch, latch clear
      {5'b00010, 1'b0, 6'h09, 12'h551},  // R9 page buffer 9
      {5'b01000, 1'b1, 6'h08, 12'h648},  // R6 first call
      {5'b00010, 1'b0, 6'h03, 12'h649},  // R9 page buffer 3
      {5'b10000, 1'b1, 6'h30, 12'h670},  // R5 branch inside subroutine
      {5'b01000, 1'b1, 6'h3F, 12'h67F},  // R7 call inside subroutine
      {5'b00000, 1'b0, 6'h00, 12'h640},  // R3 wrap 63 -> 0
      {5'b00011, 1'b0, 6'h06, 12'h641},  // R10 transfer with load-page
      {5'b00001, 1'b0, 6'h00, 12'h642},  // R10 chapter buffer 2
      {5'b00100, 1'b0, 6'h00, 12'h592},  // R8 return restores
      {5'b00100, 1'b0, 6'h00, 12'h593},  // R8 return with latch clear
      {5'b01000, 1'b0, 6'h05, 12'h594},  // R4 call not taken
      {5'b11100, 1'b1, 6'h00, 12'h595},  // R11 return wins
      {5'b11000, 1'b1, 6'h22, 12'h9A2},  // R11 call wins over branch
      {5'b01010, 1'b1, 6'h0B, 12'h98B},  // R9 load-page wins over call
      {5'b00100, 1'b0, 6'h00, 12'h6D6}   // R8 return after mixed step
   };

   function automatic string vtag(input int i);
      case (i)
         0, 10:          return "R3";
         1, 5, 7, 18:    return "R9";
         2, 11, 12:      return "R10";
         3, 15:          return "R4";
         4, 8:           return "R5";
         6:              return "R6";
         9:              return "R7";
         16, 17:         return "R11";
         default:        return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
      nvec++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s rom_addr actual=%03h expected=%03h", tag, got, exp);
      end
   endtask

   task automatic do_step(input logic [4:0] ops, input logic st, input logic [5:0] im);
      @(negedge clk);
      {op_br, op_call, op_ret, op_ldp, op_tpc} = ops;
      status = st;
      imm    = im;
      step   = 1'b1;
      @(negedge clk);
      step = 1'b0;
      {op_br, op_call, op_ret, op_ldp, op_tpc} = '0;
      status = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", rom_addr, 12'h000);
      rst_n = 1'b1;

      for (int i = 0; i < 20; i++) begin
         do_step(VEC[i][23:19], VEC[i][18], VEC[i][17:12]);
         check(vtag(i), rom_addr, VEC[i][11:0]);
      end

      // R2: operations without a step strobe change nothing
      @(negedge clk);
      op_br = 1'b1; op_call = 1'b1; op_ldp = 1'b1; status = 1'b1; imm = 6'h3A;
      repeat (3) @(negedge clk);
      check("R2", rom_addr, 12'h6D6);
      op_br = 1'b0; op_call = 1'b0; op_ldp = 1'b0; status = 1'b0;

      // R1: reset mid-run clears the address and the buffers
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", rom_addr, 12'h000);
      rst_n = 1'b1;
      do_step(5'b10000, 1'b1, 6'h07);
      check("R1", rom_addr, 12'h007);
      do_step(5'b01000, 1'b1, 6'h01);
      check("R6", rom_addr, 12'h001);
      do_step(5'b00100, 1'b0, 6'h00);
      check("R8", rom_addr, 12'h008);

      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule